// File: doc/BRIEF.md
# Indexed Operand Address Modifier

This block forms the effective operand address of an instruction. When a new instruction is presented, it loads the address field into an operand address register. It also captures the 6-bit index selector and a flag that says whether the instruction will need a memory cycle. If the selector names an index register, the block brings that register's value into a private modify register. It then adds the modify register to the operand address. The addition is decimal on the three low digits and binary on the top character.

Seventeen index registers can be named. Two are held inside the block, and a load or copy path writes them through a small write port. The other fifteen are memory words 1 to 15, which the block reads over a request/acknowledge port. When the result is ready, the block raises `done` for one cycle. In that same cycle it raises `illegal_addr` if the instruction needs memory and the addressed module is not fitted.

An address is 18 bits. Bits [17:12] hold the top character, a binary value 0..63 that counts thousands. Bits [11:8], [7:4] and [3:0] hold the hundreds, tens and units BCD digits. The module number is bits [17:14].

Top module: `opaddr_indexer`

## Requirements
- R1: After reset, `done`, `illegal_addr` and `mem_req` are 0, and `xmod_q` and `eff_addr` are 0.
- R2: If `idx_sel` is 0 or greater than 17 when a start is accepted, `eff_addr` equals the address field. `done` is high in the first cycle after the accepting edge, and no memory request is made.
- R3: `idx_sel` 16 selects internal index register A, and 17 selects internal index register B. `done` is high in the third cycle after the accepting edge, and no memory request is made.
- R4: `idx_sel` 1..15 raises `mem_req`, with `mem_addr` equal to the selector, until `mem_ack` is sampled high. `done` is high in the third cycle after the edge that samples the acknowledge.
- R5: The effective address is the address field plus the index value. The three low digits add in BCD with carries. The top character adds in binary with the incoming carry, and any carry out of it is dropped, so 63999 + 1 gives 00000.
- R6: `xmod_q` takes the selected index value during the copy step, and changes at no other time. Writes to the internal index registers leave it unchanged.
- R7: `illegal_addr` is high together with `done` exactly when `mem_needed` was 1 at start and `mod_fitted[eff_addr[17:14]]` is 0.
- R8: An internal index register write that falls in the copy cycle for that same register copies the old value, and the register keeps the new value for later instructions.
- R9: A start while an address is being formed is ignored.
- R10: `done` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin forming an address (accepted when idle) |
| addr_field | input | 18 | Instruction address field |
| idx_sel | input | 6 | Index selector character |
| mem_needed | input | 1 | Instruction will perform a memory cycle |
| mod_fitted | input | 16 | One bit per memory module, 1 = fitted |
| ix_wr_en | input | 1 | Write an internal index register |
| ix_wr_sel | input | 1 | 0 = register A, 1 = register B |
| ix_wr_data | input | 18 | Value to write |
| mem_req | output | 1 | Index word read request |
| mem_addr | output | 4 | Memory word number (1..15) |
| mem_ack | input | 1 | Read data valid |
| mem_rdata | input | 18 | Low four characters of the word read |
| done | output | 1 | Effective address valid |
| eff_addr | output | 18 | Effective operand address |
| illegal_addr | output | 1 | Unfitted module addressed with a memory cycle needed |
| xmod_q | output | 18 | Modify register, for display only |

## Verification
A program write to an internal index register can land in the same cycle in which that register is copied into the modify register. The bench provokes this by driving the write in the cycle right after the start of an instruction that selects register A. It checks that both the modify register and the sum carry the old value, and that the next instruction using A sees the new one. A second overlap, a new start arriving while a memory fetch is pending, is judged by the unchanged latency and result of the running operation.

// File: rtl/opaddr_indexer.sv
module opaddr_indexer #(
  parameter int AW = 18,
  parameter int SW = 6,
  parameter int NMOD = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] addr_field,
  input  logic [SW-1:0] idx_sel,
  input  logic          mem_needed,
  input  logic [NMOD-1:0] mod_fitted,
  input  logic          ix_wr_en,
  input  logic          ix_wr_sel,
  input  logic [AW-1:0] ix_wr_data,
  output logic          mem_req,
  output logic [3:0]    mem_addr,
  input  logic          mem_ack,
  input  logic [AW-1:0] mem_rdata,
  output logic          done,
  output logic [AW-1:0] eff_addr,
  output logic          illegal_addr,
  output logic [AW-1:0] xmod_q
);
  localparam int ND = 3;
  localparam int TW = AW - 4*ND;
  localparam int MB = $clog2(NMOD);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_COPY, S_ADD, S_DONE} st_t;

  st_t           state;
  logic [AW-1:0] oa, rdbuf, xs_a, xs_b;
  logic [SW-1:0] xh;
  logic          need_q;

  function automatic logic [AW-1:0] mix_add(input logic [AW-1:0] a, input logic [AW-1:0] b);
    logic [AW-1:0] r;
    logic [4:0]    s;
    logic          c;
    c = 1'b0;
    r = '0;
    for (int i = 0; i < ND; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b[4*i +: 4]} + {4'b0, c};
      if (s > 5'd9) begin
        s = s - 5'd10;
        c = 1'b1;
      end else begin
        c = 1'b0;
      end
      r[4*i +: 4] = s[3:0];
    end
    r[AW-1 -: TW] = a[AW-1 -: TW] + b[AW-1 -: TW] + {{(TW-1){1'b0}}, c};
    return r;
  endfunction

  wire sel_static = (idx_sel == SW'(16)) || (idx_sel == SW'(17));
  wire sel_mem    = (idx_sel != '0) && (idx_sel < SW'(16));
  wire accept     = (state == S_IDLE) && start;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      oa     <= '0;
      xh     <= '0;
      need_q <= 1'b0;
      rdbuf  <= '0;
      xmod_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          oa     <= addr_field;
          xh     <= idx_sel;
          need_q <= mem_needed;
          state  <= sel_static ? S_COPY : (sel_mem ? S_FETCH : S_DONE);
        end
        S_FETCH: if (mem_ack) begin
          rdbuf <= mem_rdata;
          state <= S_COPY;
        end
        S_COPY: begin
          xmod_q <= (xh == SW'(16)) ? xs_a : ((xh == SW'(17)) ? xs_b : rdbuf);
          state  <= S_ADD;
        end
        S_ADD: begin
          oa    <= mix_add(oa, xmod_q);
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xs_a <= '0;
      xs_b <= '0;
    end else if (ix_wr_en) begin
      if (ix_wr_sel) xs_b <= ix_wr_data;
      else           xs_a <= ix_wr_data;
    end
  end

  assign mem_req      = (state == S_FETCH);
  assign mem_addr     = xh[3:0];
  assign done         = (state == S_DONE);
  assign eff_addr     = oa;
  assign illegal_addr = done && need_q && !mod_fitted[oa[AW-1 -: MB]];

  p_req_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr != 4'd0));

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_illegal_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_addr |-> done);

  p_xmod_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_COPY) |=> $stable(xmod_q));

  p_bypass_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !sel_static && !sel_mem) |=> (done && !mem_req && eff_addr == $past(addr_field)));

  p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_FETCH && !mem_ack) |=> (state == S_FETCH));
endmodule

// File: tb/opaddr_indexer_tb_top.sv
`timescale 1ns/1ps
module opaddr_indexer_tb_top;
  logic        clk = 0, rst_n = 0, start = 0, mem_needed = 0;
  logic [17:0] addr_field = '0, ix_wr_data = '0, mem_rdata = '0;
  logic [5:0]  idx_sel = '0;
  logic [15:0] mod_fitted = 16'h00FF;
  logic        ix_wr_en = 0, ix_wr_sel = 0, mem_ack = 0;
  logic        mem_req, done, illegal_addr;
  logic [3:0]  mem_addr;
  logic [17:0] eff_addr, xmod_q;

  always #2.5 clk = ~clk;

  opaddr_indexer dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .addr_field(addr_field),
    .idx_sel(idx_sel), .mem_needed(mem_needed), .mod_fitted(mod_fitted),
    .ix_wr_en(ix_wr_en), .ix_wr_sel(ix_wr_sel), .ix_wr_data(ix_wr_data),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .eff_addr(eff_addr),
    .illegal_addr(illegal_addr), .xmod_q(xmod_q));

  int n_chk = 0, n_fail = 0, lat_cnt = 0;
  bit finished = 0;
  logic [17:0] memw [1:15];
  int xa_v = 0, xb_v = 0;

  function automatic logic [17:0] to_addr(int v);
    logic [17:0] r;
    r[17:12] = 6'(v / 1000);
    r[11:8]  = 4'((v / 100) % 10);
    r[7:4]   = 4'((v / 10) % 10);
    r[3:0]   = 4'(v % 10);
    return r;
  endfunction

  function automatic int to_int(logic [17:0] a);
    return int'(a[17:12]) * 1000 + int'(a[11:8]) * 100 + int'(a[7:4]) * 10 + int'(a[3:0]);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (mem_req && !mem_ack) begin
      if (lat_cnt == 2) begin
        mem_ack   <= 1;
        mem_rdata <= memw[mem_addr];
        lat_cnt   <= 0;
      end else lat_cnt <= lat_cnt + 1;
    end else mem_ack <= 0;
  end

  task automatic wr_ix(bit which, int v);
    @(negedge clk);
    ix_wr_en = 1; ix_wr_sel = which; ix_wr_data = to_addr(v);
    @(negedge clk);
    ix_wr_en = 0;
  endtask

  // inject: 0 none, 1 write register A in the copy cycle, 2 restart while busy
  task automatic run_op(int sel, int av, int need, int inject, int newv,
                        output int lat, output int eff, output bit ill,
                        output bit req_seen, output bit addr_bad, output bit done_after);
    int n;
    @(negedge clk);
    start = 1; idx_sel = 6'(sel); addr_field = to_addr(av); mem_needed = need[0];
    n = 0; req_seen = 0; addr_bad = 0;
    forever begin
      @(negedge clk);
      n++;
      start = 0; ix_wr_en = 0;
      if (inject == 1 && n == 1) begin ix_wr_en = 1; ix_wr_sel = 0; ix_wr_data = to_addr(newv); end
      if (inject == 2 && n == 2) begin start = 1; idx_sel = 6'd0; addr_field = to_addr(777); end
      if (mem_req) begin req_seen = 1; if (int'(mem_addr) != sel) addr_bad = 1; end
      if (done || n > 40) break;
    end
    start = 0; ix_wr_en = 0;
    lat = n; eff = to_int(eff_addr); ill = illegal_addr;
    @(negedge clk);
    done_after = done;
  endtask

  // {sel, address, mem_needed, latency after start edge}
  localparam int NV = 8;
  localparam int VEC [NV][4] = '{
    '{0, 12345, 0, 1}, '{20, 500, 1, 1}, '{16, 999, 0, 3}, '{17, 63999, 1, 3},
    '{3, 7999, 1, 6}, '{15, 40000, 1, 6}, '{5, 40000, 0, 6}, '{1, 0, 1, 6}};

  initial begin
    int lat, eff, idxv, expv;
    bit ill, rq, ab, da, exp_ill;
    for (int k = 1; k <= 15; k++) memw[k] = to_addr((k * 1013) % 64000);
    repeat (3) @(negedge clk);
    chk(done == 0 && illegal_addr == 0 && mem_req == 0, "R1", "outputs at reset", int'(done), 0);
    chk(xmod_q == 0 && eff_addr == 0, "R1", "regs at reset", int'(xmod_q), 0);
    rst_n = 1;

    xa_v = 1001; xb_v = 1;
    wr_ix(0, xa_v);
    wr_ix(1, xb_v);
    @(negedge clk);
    chk(xmod_q == 0, "R6", "xmod after index writes", int'(xmod_q), 0);

    for (int v = 0; v < NV; v++) begin
      int sel, av, need;
      sel = VEC[v][0]; av = VEC[v][1]; need = VEC[v][2];
      idxv = (sel == 16) ? xa_v : (sel == 17) ? xb_v :
             (sel >= 1 && sel <= 15) ? to_int(memw[sel]) : 0;
      expv = (av + idxv) % 64000;
      exp_ill = need != 0 && !mod_fitted[expv / 4000];
      run_op(sel, av, need, 0, 0, lat, eff, ill, rq, ab, da);
      chk(eff == expv, "R5", $sformatf("sum vec %0d", v), eff, expv);
      chk(lat == VEC[v][3], (sel >= 1 && sel <= 15) ? "R4" : (sel == 16 || sel == 17) ? "R3" : "R2",
          $sformatf("latency vec %0d", v), lat, VEC[v][3]);
      chk(rq == (sel >= 1 && sel <= 15) && !ab, "R4", $sformatf("request vec %0d", v), int'(rq), int'(sel >= 1 && sel <= 15));
      chk(ill == exp_ill, "R7", $sformatf("illegal vec %0d", v), int'(ill), int'(exp_ill));
      chk(da == 0, "R10", $sformatf("done pulse vec %0d", v), int'(da), 0);
      if (sel != 0 && sel <= 17)
        chk(to_int(xmod_q) == idxv, "R6", $sformatf("xmod vec %0d", v), to_int(xmod_q), idxv);
    end

    idxv = to_int(xmod_q);
    wr_ix(1, 5);
    chk(to_int(xmod_q) == idxv, "R6", "xmod unchanged by write", to_int(xmod_q), idxv);
    xb_v = 5;

    run_op(16, 2000, 0, 1, 3, lat, eff, ill, rq, ab, da);
    chk(to_int(xmod_q) == 1001, "R8", "copy takes old value", to_int(xmod_q), 1001);
    chk(eff == 3001, "R8", "sum with old value", eff, 3001);
    run_op(16, 2000, 0, 0, 0, lat, eff, ill, rq, ab, da);
    chk(eff == 2003, "R8", "register holds new value", eff, 2003);

    run_op(2, 100, 0, 2, 0, lat, eff, ill, rq, ab, da);
    expv = (100 + to_int(memw[2])) % 64000;
    chk(lat == 6 && eff == expv, "R9", "restart while busy ignored", eff, expv);
    chk(da == 0, "R9", "no extra done from ignored start", int'(da), 0);

    run_op(17, 63999, 1, 0, 0, lat, eff, ill, rq, ab, da);
    chk(eff == 4, "R5", "wrap past top", eff, 4);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule